// File: doc/BRIEF.md
# Serial SRAM SPI Master Controller

This block runs whole transactions against a byte-addressed serial SRAM over a four-wire SPI link. A host issues one request at a time: a command kind, a 17-bit byte address and a byte count. Write bytes arrive on a ready/valid byte stream. Bytes read back leave on a second stream that is qualified by a one-cycle valid. The controller pulls chip select low and sends the command byte and the address header. It then moves the data burst and raises chip select again. Consecutive bytes need no host software in between.

Every byte of a frame follows the previous one with no idle serial clock, as long as the write stream keeps up. This lets a burst run at the full SCK rate. The same framing also reads and writes the memory's one-byte mode/status register. The serial clock is the system clock divided by an even ratio `CLK_DIV`. The hold pin of the memory is tied inactive.

Top module: `spi_sram_master`

## Requirements
- R1: `req_ready` is high exactly when no transaction is in progress, and a request is taken only then. `busy` rises in the same cycle that `spi_cs_n` falls and stays high until `spi_cs_n` rises. A `req_valid` held while busy starts no extra frame.
- R2: Command kinds map to opcode bytes: kind 0 gives 0x01 (status write), kind 1 gives 0x02 (data write), kind 2 gives 0x03 (data read) and kind 3 gives 0x05 (status read).
- R3: A data command (kind 1 or 2) sends the opcode byte and then three address bytes. The address bytes carry the 24-bit value {7 zero bits, `req_addr`}, most significant byte first. Exactly `req_len` data bytes follow. A length of 0 gives a four-byte frame.
- R4: A status command (kind 0 or 3) sends the opcode byte and then exactly one data byte, with no address.
- R5: SPI mode 0. `spi_sck` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sck` is low. Bits go out most significant first, and `spi_miso` is sampled on the rising edge.
- R6: One SCK period is `CLK_DIV` clock cycles. Within a frame, successive rising edges are exactly `CLK_DIV` cycles apart, byte boundaries included, unless a write byte is late.
- R7: The first rising SCK edge comes `CLK_DIV` cycles after `spi_cs_n` falls. `spi_cs_n` rises `CLK_DIV` cycles after the last falling edge.
- R8: During the data bytes of a read, `spi_mosi` carries 0xFF. Each received byte appears on `rd_data` with a one-cycle `rd_valid`, in the order received, while `spi_cs_n` is still low.
- R9: A write byte is consumed on a cycle with `wr_valid` and `wr_ready` both high. If it is not valid when needed, `spi_sck` stays low until it is supplied.
- R10: `spi_hold_n` is always 1.
- R11: `done` is a one-cycle pulse in the cycle where `spi_cs_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_kind | input | 2 | Command kind (see R2) |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Data byte count for data commands |
| wr_data | input | 8 | Write byte stream data |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte is taken this cycle if valid |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte strobe |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction complete pulse |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |
| spi_hold_n | output | 1 | Hold, held inactive |

## Verification
If the byte sequencer goes wrong, the model's decoded frame no longer matches the request when chip select rises. Typical faults are a lost header byte, a count off by one or the wrong opcode. Wrong data from a mis-sampled bit shows up on the read stream within the same byte time. A bad clock divider or a missed preload breaks the rising-edge spacing at the next SCK edge, so the per-clock timing checks catch it within one serial period. Handshake faults show up within a few cycles of the fault. A stall that keeps the clock running, or a request taken while busy, gives an SCK high during a stall or an extra chip-select window.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

  typedef enum logic [1:0] {
    CMD_WR_STATUS = 2'd0,
    CMD_WR_DATA   = 2'd1,
    CMD_RD_DATA   = 2'd2,
    CMD_RD_STATUS = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_WAIT,
    ST_HOLD
  } state_e;

  function automatic logic [7:0] cmd_opcode(input cmd_e c);
    case (c)
      CMD_WR_STATUS: cmd_opcode = 8'h01;
      CMD_WR_DATA:   cmd_opcode = 8'h02;
      CMD_RD_DATA:   cmd_opcode = 8'h03;
      default:       cmd_opcode = 8'h05;
    endcase
  endfunction

  function automatic logic cmd_has_addr(input cmd_e c);
    cmd_has_addr = (c == CMD_WR_DATA) || (c == CMD_RD_DATA);
  endfunction

  function automatic logic cmd_is_read(input cmd_e c);
    cmd_is_read = (c == CMD_RD_DATA) || (c == CMD_RD_STATUS);
  endfunction

endpackage

// File: rtl/sram_spi_tick.sv
module sram_spi_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/sram_spi_shifter.sv
module sram_spi_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       shift,
  input  logic       sample,
  input  logic       miso_i,
  output logic       mosi_o,
  output logic [7:0] rx_o
);
  logic [7:0] tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_o <= '0;
    end else begin
      if (load)       tx_q <= load_val;
      else if (shift) tx_q <= {tx_q[6:0], 1'b0};
      if (sample)     rx_o <= {rx_o[6:0], miso_i};
    end
  end

  assign mosi_o = tx_q[7];
endmodule

// File: rtl/spi_sram_master.sv
module spi_sram_master
  import sram_spi_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 17,
  parameter int LEN_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_hold_n
);
  localparam int HALF  = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int HDR_W = 24;

  state_e            state;
  cmd_e              kind;
  logic              tick, run;
  logic [2:0]        bitcnt;
  logic [HDR_W-1:0]  hdr_q;
  logic [1:0]        hdr_left;
  logic [LEN_W-1:0]  dleft;
  logic              cur_data, is_rd, hold_ph;
  logic              rise_ev, fall_ev, byte_end, accept;
  logic              sh_load, sh_shift;
  logic [7:0]        sh_val, rx_byte;

  assign kind     = cmd_e'(req_kind);
  assign run      = (state == ST_SETUP) || (state == ST_SHIFT) || (state == ST_HOLD);
  assign rise_ev  = (state == ST_SHIFT) && tick && !spi_sck;
  assign fall_ev  = (state == ST_SHIFT) && tick && spi_sck;
  assign byte_end = fall_ev && (bitcnt == 3'd7);
  assign accept   = req_valid && (state == ST_IDLE);

  assign req_ready  = (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign spi_hold_n = 1'b1;
  assign wr_ready   = (state == ST_WAIT) ||
                      (byte_end && hdr_left == 2'd0 && dleft != '0 && !is_rd);

  always_comb begin
    sh_load = 1'b0;
    sh_val  = 8'hFF;
    if (accept) begin
      sh_load = 1'b1;
      sh_val  = cmd_opcode(kind);
    end else if (byte_end && hdr_left != 2'd0) begin
      sh_load = 1'b1;
      sh_val  = hdr_q[HDR_W-1 -: 8];
    end else if (byte_end && dleft != '0) begin
      sh_load = is_rd || wr_valid;
      sh_val  = is_rd ? 8'hFF : wr_data;
    end else if (state == ST_WAIT) begin
      sh_load = wr_valid;
      sh_val  = wr_data;
    end
  end

  assign sh_shift = fall_ev && (bitcnt != 3'd7);

  sram_spi_tick #(.HALF(HALF)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  sram_spi_shifter u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (sh_load),
    .load_val(sh_val),
    .shift   (sh_shift),
    .sample  (rise_ev),
    .miso_i  (spi_miso),
    .mosi_o  (spi_mosi),
    .rx_o    (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      spi_sck  <= 1'b0;
      spi_cs_n <= 1'b1;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      bitcnt   <= '0;
      hdr_q    <= '0;
      hdr_left <= '0;
      dleft    <= '0;
      cur_data <= 1'b0;
      is_rd    <= 1'b0;
      hold_ph  <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          spi_cs_n <= 1'b0;
          state    <= ST_SETUP;
          hdr_q    <= {{(HDR_W-ADDR_W){1'b0}}, req_addr};
          hdr_left <= cmd_has_addr(kind) ? 2'd3 : 2'd0;
          dleft    <= cmd_has_addr(kind) ? req_len : LEN_W'(1);
          is_rd    <= cmd_is_read(kind);
          bitcnt   <= '0;
          cur_data <= 1'b0;
        end
        ST_SETUP: if (tick) state <= ST_SHIFT;
        ST_SHIFT: if (tick) begin
          spi_sck <= ~spi_sck;
          if (fall_ev) bitcnt <= bitcnt + 3'd1;
          if (byte_end) begin
            if (cur_data && is_rd) begin
              rd_valid <= 1'b1;
              rd_data  <= rx_byte;
            end
            if (hdr_left != 2'd0) begin
              hdr_q    <= {hdr_q[HDR_W-9:0], 8'h00};
              hdr_left <= hdr_left - 2'd1;
              cur_data <= 1'b0;
            end else if (dleft != '0) begin
              cur_data <= 1'b1;
              if (is_rd || wr_valid) dleft <= dleft - LEN_W'(1);
              else                   state <= ST_WAIT;
            end else begin
              state   <= ST_HOLD;
              hold_ph <= 1'b0;
            end
          end
        end
        ST_WAIT: if (wr_valid) begin
          dleft <= dleft - LEN_W'(1);
          state <= ST_SHIFT;
        end
        ST_HOLD: if (tick) begin
          if (hold_ph) begin
            spi_cs_n <= 1'b1;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            hold_ph <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_spi_checker.sv
module sram_spi_checker (
  input logic clk,
  input logic rst,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic spi_hold_n,
  input logic done,
  input logic rd_valid,
  input logic busy,
  input logic wr_ready,
  input logic wr_valid
);
  // R5: clock parked low outside a frame
  a_r5_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  // R5: data line held while the clock is high
  a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R10
  a_r10_hold_high: assert property (@(posedge clk) disable iff (rst)
    spi_hold_n);

  // R11
  a_r11_done_with_cs_rise: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(spi_cs_n));

  // R8
  a_r8_rd_inside_frame: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !spi_cs_n);

  // R1
  a_r1_busy_with_cs_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $fell(spi_cs_n));

  // R9: a stall keeps the clock low
  a_r9_stall_sck_low: assert property (@(posedge clk) disable iff (rst)
    $past(wr_ready && !wr_valid) |-> !spi_sck);
endmodule

bind spi_sram_master sram_spi_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .spi_sck   (spi_sck),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi),
  .spi_hold_n(spi_hold_n),
  .done      (done),
  .rd_valid  (rd_valid),
  .busy      (busy),
  .wr_ready  (wr_ready),
  .wr_valid  (wr_valid)
);

// File: tb/tb_spi_sram_master.sv
`timescale 1ns/1ps
module tb_spi_sram_master;
  localparam int DIV = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready;
  logic [1:0] req_kind = 0;
  logic [16:0] req_addr = 0;
  logic [15:0] req_len = 0;
  logic [7:0] wr_data = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, busy, done, spi_sck, spi_cs_n, spi_mosi, spi_hold_n;
  logic spi_miso = 0;

  spi_sram_master #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_hold_n(spi_hold_n));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench-side memory models
  logic [7:0] dev_mem[int];
  logic [7:0] gold_mem[int];
  logic [7:0] dev_status = 8'h02, gold_status = 8'h02;
  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
  endfunction
  function automatic logic [7:0] gval(input int a);
    return gold_mem.exists(a) ? gold_mem[a] : init_val(a);
  endfunction
  function automatic logic [7:0] dval(input int a);
    return dev_mem.exists(a) ? dev_mem[a] : init_val(a);
  endfunction

  logic [7:0] exp_frame[$], got_frame[$], exp_rd[$], wq[$];
  string cur_tag = "R3";
  int frames = 0, gap_cfg = 0, gap = 0;
  bit took = 0;

  // write stream feeder
  always @(negedge clk) begin
    if (took) begin void'(wq.pop_front()); took = 0; if (gap_cfg > 0) gap = gap_cfg; end
    if (gap > 0) begin gap--; wr_valid = 0; end
    else wr_valid = (wq.size() > 0);
    wr_data = (wq.size() > 0) ? wq[0] : 8'h00;
    took = wr_valid && wr_ready;
  end

  // cycle-by-cycle monitor, slave model and timing model
  int cyc = 0, cs_fall_cyc = 0, last_rise = 0, last_fall = 0;
  bit first_rise = 0, stall_seen = 0, prev_stall = 0;
  logic p_sck = 0, p_cs = 1, p_mosi = 0, p_done = 0;
  int s_bits = 0, s_n = 0, s_addr = 0;
  logic [7:0] s_in = 0, s_out = 0, s_op = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(spi_hold_n === 1'b1, "R10", "hold_n", spi_hold_n, 1);
      chk(req_ready === !busy, "R1", "ready vs busy", req_ready, !busy);
      if (spi_cs_n) chk(spi_sck === 1'b0, "R5", "sck while deselected", spi_sck, 0);
      if (spi_sck && p_sck) chk(spi_mosi === p_mosi, "R5", "mosi moved while sck high", spi_mosi, p_mosi);
      if (prev_stall) chk(spi_sck === 1'b0, "R9", "sck during stall", spi_sck, 0);
      if (done) chk(spi_cs_n && !p_cs && !p_done, "R11", "done pulse placement", {spi_cs_n, p_cs, p_done}, 3'b100);
      if (busy && !p_cs) chk(!spi_cs_n || done, "R1", "busy frame", spi_cs_n, 0);
      if (!spi_cs_n && p_cs) begin
        chk(busy === 1'b1, "R1", "busy at cs fall", busy, 1);
        cs_fall_cyc = cyc; first_rise = 1; s_bits = 0; s_n = 0; s_out = 0;
        spi_miso = 0; got_frame.delete();
      end
      if (spi_sck && !p_sck) begin
        if (first_rise) chk(cyc - cs_fall_cyc == DIV, "R7", "cs setup", cyc - cs_fall_cyc, DIV);
        else if (!stall_seen) chk(cyc - last_rise == DIV, "R6", "sck period", cyc - last_rise, DIV);
        first_rise = 0; stall_seen = 0; last_rise = cyc;
        s_in = {s_in[6:0], spi_mosi}; s_bits++;
        if (s_bits == 8) begin
          got_frame.push_back(s_in); s_n++;
          if (s_n == 1) s_op = s_in;
          if ((s_op == 8'h02 || s_op == 8'h03) && s_n >= 2 && s_n <= 4)
            s_addr = (s_n == 2) ? int'(s_in) << 16 : s_addr | (int'(s_in) << (8 * (4 - s_n)));
          if (s_op == 8'h02 && s_n > 4) begin dev_mem[s_addr] = s_in; s_addr++; end
          if (s_op == 8'h01 && s_n == 2) dev_status = s_in;
        end
      end
      if (!spi_sck && p_sck) begin
        last_fall = cyc;
        if (s_bits == 8) begin
          s_bits = 0;
          if (s_op == 8'h03 && s_n >= 4) begin s_out = dval(s_addr); s_addr++; end
          else if (s_op == 8'h05 && s_n >= 1) s_out = dev_status;
          else s_out = 8'h00;
          spi_miso = s_out[7];
        end else spi_miso = s_out[7 - s_bits];
      end
      if (spi_cs_n && !p_cs) begin
        chk(cyc - last_fall == DIV, "R7", "cs hold", cyc - last_fall, DIV);
        chk(done === 1'b1, "R11", "done at cs rise", done, 1);
        chk(got_frame.size() == exp_frame.size(), cur_tag, "frame length", got_frame.size(), exp_frame.size());
        foreach (exp_frame[i])
          if (i < got_frame.size())
            chk(got_frame[i] == exp_frame[i], (i == 0) ? "R2" : cur_tag, "frame byte", got_frame[i], exp_frame[i]);
        exp_frame.delete();
        frames++;
      end
      if (rd_valid) begin
        chk(exp_rd.size() > 0, "R8", "unexpected read byte", rd_data, 0);
        if (exp_rd.size() > 0) begin
          chk(rd_data == exp_rd[0], "R8", "read byte", rd_data, exp_rd[0]);
          void'(exp_rd.pop_front());
        end
      end
      if (wr_ready && !wr_valid) stall_seen = 1;
      prev_stall = wr_ready && !wr_valid;
      p_sck = spi_sck; p_cs = spi_cs_n; p_mosi = spi_mosi; p_done = done;
    end
  end

  task automatic run_txn(input logic [1:0] kind, input int addr, input int len,
                         input int stall, input string tag, input bit spam);
    logic [7:0] op;
    int f0;
    op = (kind == 0) ? 8'h01 : (kind == 1) ? 8'h02 : (kind == 2) ? 8'h03 : 8'h05;
    cur_tag = tag;
    exp_frame.push_back(op);
    if (kind == 1 || kind == 2) begin
      exp_frame.push_back(8'(addr >> 16));
      exp_frame.push_back(8'(addr >> 8));
      exp_frame.push_back(8'(addr));
      for (int i = 0; i < len; i++) begin
        if (kind == 1) begin
          logic [7:0] b;
          b = 8'((addr + i) * 7 + 8'h91);
          wq.push_back(b); exp_frame.push_back(b); gold_mem[addr + i] = b;
        end else begin
          exp_frame.push_back(8'hFF); exp_rd.push_back(gval(addr + i));
        end
      end
    end else if (kind == 0) begin
      wq.push_back(8'(addr)); exp_frame.push_back(8'(addr)); gold_status = 8'(addr);
    end else begin
      exp_frame.push_back(8'hFF); exp_rd.push_back(gold_status);
    end
    gap_cfg = stall; gap = stall;
    f0 = frames;
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_addr = 17'(addr); req_len = 16'(len);
    @(negedge clk);
    req_valid = 0;
    if (spam) begin
      req_kind = 2'd1; req_addr = 17'h0AAAA; req_len = 16'd3;
      req_valid = 1;
      repeat (20) @(negedge clk);
      req_valid = 0;
    end
    while (frames == f0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(frames == f0 + 1, "R1", "frames per request", frames - f0, 1);
    chk(spi_cs_n === 1'b1, "R1", "no frame after completion", spi_cs_n, 1);
    chk(exp_rd.size() == 0, "R8", "read bytes missing", exp_rd.size(), 0);
    chk(wq.size() == 0, "R9", "write bytes left", wq.size(), 0);
    exp_rd.delete(); wq.delete(); gap_cfg = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R5", "reset pins", {spi_cs_n, spi_sck}, 2'b10);
    chk(busy === 1'b0 && req_ready === 1'b1, "R1", "reset idle", {busy, req_ready}, 2'b01);
    chk(done === 1'b0 && rd_valid === 1'b0, "R11", "reset strobes", {done, rd_valid}, 0);
    run_txn(2'd1, 17'h12345, 8, 0, "R3", 0);   // data write burst, back-to-back
    run_txn(2'd2, 17'h12345, 8, 0, "R8", 0);   // read it back
    run_txn(2'd1, 17'h1FFFD, 3, 5, "R9", 0);   // stalled write at top of space
    run_txn(2'd2, 17'h1FFFC, 4, 0, "R8", 0);   // read over fresh and untouched bytes
    run_txn(2'd0, 8'h40, 0, 0, "R4", 0);       // status write
    run_txn(2'd3, 0, 0, 0, "R4", 0);           // status read
    run_txn(2'd1, 17'h00100, 0, 0, "R3", 0);   // zero-length data write
    run_txn(2'd2, 17'h00020, 6, 0, "R1", 1);   // request held while busy
    run_txn(2'd2, 17'h0AAAA, 3, 0, "R1", 0);   // ignored write left memory untouched
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule